// File: doc/BRIEF.md
# Two-Level SMI Status Aggregator

This block collects system-management interrupt events from a set of internal power-management triggers and from eight external pins. It reports them through a small word-addressed register bank on a simple read/write bus. Each event source sets a second-level status bit when its enable allows it. The second-level bits feed two top-level summary bits, and those drive one active-high SMI output.

Every status group can be read in two ways. One view clears the status as a side effect of the read. The other is a mirror view that returns the same bits and clears nothing, so a handler can inspect the sources without dropping the SMI. External pins are synchronized and edge-detected before they set status. An event that coincides with a clearing read is never lost.

The bus uses word addresses with per-byte lane enables. Read data is combinational in the cycle where `bus_sel` is high and `bus_wr` is low. Any clearing side effect takes place at the clock edge that ends that cycle.

Top module: `smi_status_agg`

## Requirements
- R1: A pulse on `ev_cmd_wr` sets internal status bit 0 at the next clock edge, whatever the enables hold.
- R2: The enable word (address 4) holds the throttle enable in bit 0, the sleep enable in bit 1 and the level-3-read enable in bit 2. Status bit 1 (throttle), bit 2 (sleep) and bit 4 (level-3 read) are set by their event only while the matching enable is 1.
- R3: The BIOS event sets internal status bit 5 only when both enable bits 3 and 4 are 1.
- R4: A read of address 2 with byte lane 0 enabled returns the internal status in bits 5:0. That read clears the internal status and summary bit 2 at the clock edge ending the read. Bits 31:6 and bit 3 always read 0.
- R5: A read of address 1 returns the same value as address 2, clears nothing, and leaves `smi_o` unchanged.
- R6: The external word (address 3) layout is as follows:
  - bits 7:0 are the read/write pin enables, written through lane 0;
  - bits 15:8 mirror the pin status;
  - bits 23:16 are the pin status;
  - bits 31:24 read 0;
  - writes to bits 31:8 have no effect.
- R7: A rising edge on an enabled `ext_smi_pin` bit sets its status at the third clock edge after the pin changes. A pin held high does not set its status again, and a disabled pin sets nothing.
- R8: A read of address 3 with lane 2 enabled clears the pin status and summary bit 10 at the edge ending the read. With lane 2 disabled, the read clears nothing.
- R9: The summary word (address 0) shows bit 2 as the OR of the internal status and bit 10 as the OR of the pin status. Reading it clears nothing.
- R10: `smi_o` is the OR of the summary bits. It is low in the cycle right after the read that clears the last set status bit.
- R11: An event arriving in the same cycle as a clearing read of its group leaves its status bit set.
- R12: After reset, every register reads 0 except the enable word, which reads 0x00000007. `smi_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| ev_cmd_wr | input | 1 | SMI command port written |
| ev_throttle | input | 1 | Throttle enable bit written with 1 |
| ev_sleep | input | 1 | Sleep enable bit written with 1 |
| ev_lvl3_rd | input | 1 | Level-3 register read |
| ev_bios | input | 1 | Software raised an event to firmware |
| ext_smi_pin | input | N_EXT | Asynchronous external SMI requests |
| smi_o | output | 1 | Active SMI request |

## Verification
The assertions check on every cycle the properties that hold for any traffic:
- a set event always survives a coincident clear;
- a clear without a set always empties its bits;
- the command event always sets bit 0;
- the BIOS event stays blocked unless both gates are on;
- a mirror read never drops a bit;
- the summary bits track their groups;
- a synchronized edge pulses for only one cycle.

Only the bench scenarios can show the things that need a whole sequence of traffic:
- the exact register layouts and the reset values;
- the three-edge latency of the pins;
- the lane-dependent clearing of the external word;
- the moment `smi_o` falls after a read.

// File: rtl/smi_agg_pkg.sv
`timescale 1ns/1ps
package smi_agg_pkg;
   localparam int DATA_W = 32;

   // word addresses
   localparam int A_SUMMARY    = 0;
   localparam int A_INT_MIRROR = 1;
   localparam int A_INT_RC     = 2;
   localparam int A_EXT        = 3;
   localparam int A_INT_EN     = 4;

   // internal status bit positions (decoded by the firmware handler)
   localparam int INT_W  = 6;
   localparam int IB_CMD = 0;
   localparam int IB_THR = 1;
   localparam int IB_SLP = 2;
   localparam int IB_L3  = 4;
   localparam int IB_BIO = 5;

   // summary bit positions
   localparam int SB_INT = 2;
   localparam int SB_EXT = 10;

   typedef struct packed {
      logic bios_b;
      logic bios_a;
      logic lvl3;
      logic sleep;
      logic throttle;
   } int_en_t;

   localparam int_en_t INT_EN_RST = '{bios_b: 1'b0, bios_a: 1'b0,
                                      lvl3: 1'b1, sleep: 1'b1, throttle: 1'b1};
endpackage

// File: rtl/smi_pin_sync.sv
`timescale 1ns/1ps
module smi_pin_sync #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] rise_o
);
   localparam int MSB = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("smi_pin_sync: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_n
      $error("smi_pin_sync: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i[i]};
            prev_q  <= chain_q[MSB];
         end
      end

      assign rise_o[i] = chain_q[MSB] & ~prev_q;
   end

   // R7: an edge indication lasts one cycle only
   p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/smi_status_bank.sv
`timescale 1ns/1ps
module smi_status_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o,
   output logic         any_next_o
);
   if (W < 1) begin : g_bad_w
      $error("smi_status_bank: W must be at least 1");
   end

   logic [W-1:0] q_d;

   always_comb begin
      q_d = (q_o & ~clr_i) | set_i;
   end

   assign any_next_o = |q_d;

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= q_d;
   end

   // R11: a set in the same cycle as a clear wins
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R4 / R8: cleared bits without a set are empty afterwards
   p_clear_r4_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/smi_status_agg.sv
`timescale 1ns/1ps
module smi_status_agg
   import smi_agg_pkg::*;
#(
   parameter int N_EXT       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ev_cmd_wr,
   input  logic              ev_throttle,
   input  logic              ev_sleep,
   input  logic              ev_lvl3_rd,
   input  logic              ev_bios,
   input  logic [N_EXT-1:0]  ext_smi_pin,
   output logic              smi_o
);
   localparam int EXT_LANE = 8;

   if (N_EXT < 1 || N_EXT > EXT_LANE) begin : g_bad_next
      $error("smi_status_agg: N_EXT must be 1..8");
   end
   if ((1 << ADDR_W) <= A_INT_EN) begin : g_bad_addr
      $error("smi_status_agg: ADDR_W too small for the register map");
   end

   // bus decode
   logic rd, wr;
   logic hit_sum, hit_mir, hit_rc, hit_ext, hit_en;

   assign rd      = bus_sel & ~bus_wr;
   assign wr      = bus_sel &  bus_wr;
   assign hit_sum = (bus_addr == ADDR_W'(A_SUMMARY));
   assign hit_mir = (bus_addr == ADDR_W'(A_INT_MIRROR));
   assign hit_rc  = (bus_addr == ADDR_W'(A_INT_RC));
   assign hit_ext = (bus_addr == ADDR_W'(A_EXT));
   assign hit_en  = (bus_addr == ADDR_W'(A_INT_EN));

   logic unused_ok;
   assign unused_ok = ^{bus_wdata[31:N_EXT], bus_be[3], bus_be[1]};

   // enable registers
   int_en_t          en_q;
   logic [N_EXT-1:0] ext_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= INT_EN_RST;
         ext_en_q <= '0;
      end else begin
         if (wr && hit_en && bus_be[0])  en_q     <= int_en_t'(bus_wdata[4:0]);
         if (wr && hit_ext && bus_be[0]) ext_en_q <= bus_wdata[N_EXT-1:0];
      end
   end

   // internal second-level status
   logic [INT_W-1:0] int_set, int_clr, int_st;
   logic             int_any_next;

   always_comb begin
      int_set         = '0;
      int_set[IB_CMD] = ev_cmd_wr;
      int_set[IB_THR] = ev_throttle & en_q.throttle;
      int_set[IB_SLP] = ev_sleep    & en_q.sleep;
      int_set[IB_L3]  = ev_lvl3_rd  & en_q.lvl3;
      int_set[IB_BIO] = ev_bios & en_q.bios_a & en_q.bios_b;
   end

   assign int_clr = {INT_W{rd & hit_rc & bus_be[0]}};

   smi_status_bank #(.W(INT_W)) u_int_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (int_set),
      .clr_i     (int_clr),
      .q_o       (int_st),
      .any_next_o(int_any_next)
   );

   // external pins
   logic [N_EXT-1:0] ext_rise, ext_set, ext_clr, ext_st;
   logic             ext_any_next;

   smi_pin_sync #(.N(N_EXT), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (ext_smi_pin),
      .rise_o(ext_rise)
   );

   assign ext_set = ext_rise & ext_en_q;
   assign ext_clr = {N_EXT{rd & hit_ext & bus_be[2]}};

   smi_status_bank #(.W(N_EXT)) u_ext_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (ext_set),
      .clr_i     (ext_clr),
      .q_o       (ext_st),
      .any_next_o(ext_any_next)
   );

   // top-level summary, updated on the same edge as the status
   logic sum_int_q, sum_ext_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_int_q <= 1'b0;
         sum_ext_q <= 1'b0;
      end else begin
         sum_int_q <= int_any_next;
         sum_ext_q <= ext_any_next;
      end
   end

   assign smi_o = sum_int_q | sum_ext_q;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if (hit_sum) begin
            bus_rdata[SB_INT] = sum_int_q;
            bus_rdata[SB_EXT] = sum_ext_q;
         end else if (hit_mir || hit_rc) begin
            bus_rdata = 32'(int_st);
         end else if (hit_ext) begin
            bus_rdata = {8'h00, 8'(ext_st), 8'(ext_st), 8'(ext_en_q)};
         end else if (hit_en) begin
            bus_rdata = 32'(en_q);
         end
      end
   end

   // R1: the command event is never gated
   p_cmd_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cmd_wr |=> int_st[IB_CMD]);

   // R3: BIOS event blocked unless both gates are on
   p_bios_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_bios && !(en_q.bios_a && en_q.bios_b) && !int_st[IB_BIO])
      |=> !int_st[IB_BIO]);

   // R5: a mirror read never drops a bit
   p_mirror_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit_mir) |=> ((int_st & $past(int_st)) == $past(int_st)));

   // R9: summary bits follow their groups
   p_sum_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_int_q == (|int_st)) && (sum_ext_q == (|ext_st)));

   // R10: SMI drops right after the last status is cleared
   p_smi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit_rc && bus_be[0] && !(|int_set) && !(|ext_set) && !sum_ext_q)
      |=> !smi_o);
endmodule

// File: tb/smi_status_agg_bench.sv
`timescale 1ns/1ps
module smi_status_agg_bench;
   localparam int ADDR_W = 4;
   localparam int N_EXT  = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_sel, bus_wr;
   logic [ADDR_W-1:0] bus_addr;
   logic [3:0]        bus_be;
   logic [31:0]       bus_wdata, bus_rdata;
   logic              ev_cmd_wr, ev_throttle, ev_sleep, ev_lvl3_rd, ev_bios;
   logic [N_EXT-1:0]  ext_smi_pin;
   logic              smi_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   smi_status_agg #(.N_EXT(N_EXT), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_smi_status_agg (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ev_cmd_wr(ev_cmd_wr), .ev_throttle(ev_throttle),
      .ev_sleep(ev_sleep), .ev_lvl3_rd(ev_lvl3_rd), .ev_bios(ev_bios),
      .ext_smi_pin(ext_smi_pin), .smi_o(smi_o)
   );

   // {event mask [cmd,thr,slp,l3,bios] lsb first, enable word, expected status}
   localparam logic [25:0] VEC [8] = '{
      {5'b00001, 5'b00000, 16'h0001},   // R1 ungated
      {5'b00010, 5'b00001, 16'h0002},   // R2 throttle enabled
      {5'b00010, 5'b00000, 16'h0000},   // R2 throttle disabled
      {5'b01100, 5'b00110, 16'h0014},   // R2 sleep + level-3
      {5'b10000, 5'b01000, 16'h0000},   // R3 one gate only
      {5'b10000, 5'b11000, 16'h0020},   // R3 both gates
      {5'b11111, 5'b11111, 16'h0037},   // R4 all, bit 3 stays 0
      {5'b11111, 5'b11101, 16'h0033}    // R2 sleep masked
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic bus_rd(input int a, input logic [3:0] be, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a); bus_be = be;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_wrt(input int a, input logic [3:0] be, input logic [31:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_be = be; bus_wdata = v;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] m);
      @(negedge clk);
      {ev_bios, ev_lvl3_rd, ev_sleep, ev_throttle, ev_cmd_wr} = m;
      @(negedge clk);
      {ev_bios, ev_lvl3_rd, ev_sleep, ev_throttle, ev_cmd_wr} = '0;
   endtask

   initial begin
      #500000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0;
      bus_wdata = '0; ext_smi_pin = '0;
      {ev_bios, ev_lvl3_rd, ev_sleep, ev_throttle, ev_cmd_wr} = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R12 reset state
      check("R12 smi", 32'(smi_o), 32'h0);
      bus_rd(4, 4'hF, d); check("R12 enables", d, 32'h7);
      bus_rd(0, 4'hF, d); check("R12 summary", d, 32'h0);
      bus_rd(3, 4'hF, d); check("R12 ext word", d, 32'h0);
      bus_rd(1, 4'hF, d); check("R12 mirror", d, 32'h0);

      // vector table: R1 R2 R3 R4 R5 R10
      foreach (VEC[i]) begin
         bus_wrt(4, 4'h1, 32'(VEC[i][20:16]));
         pulse(VEC[i][25:21]);
         bus_rd(1, 4'hF, d); check("R5 mirror value", d, 32'(VEC[i][15:0]));
         check("R5 smi kept", 32'(smi_o), 32'(VEC[i][15:0] != 0));
         bus_rd(2, 4'hF, d); check("R1/R2/R3/R4 status", d, 32'(VEC[i][15:0]));
         check("R10 smi low after clear", 32'(smi_o), 32'h0);
         bus_rd(1, 4'hF, d); check("R4 cleared", d, 32'h0);
      end
      bus_wrt(4, 4'h1, 32'h7);

      // R9 summary bit 2, no clear on summary read
      pulse(5'b00001);
      bus_rd(0, 4'hF, d); check("R9 summary int", d, 32'h4);
      bus_rd(0, 4'hF, d); check("R9 summary kept", d, 32'h4);

      // R11 event during clearing read
      @(negedge clk);
      ev_throttle = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd2; bus_be = 4'hF;
      #1 check("R11 read value", bus_rdata, 32'h1);
      @(negedge clk);
      ev_throttle = 1'b0; bus_sel = 1'b0;
      bus_rd(1, 4'hF, d); check("R11 event kept", d, 32'h2);
      check("R11 smi", 32'(smi_o), 32'h1);
      bus_rd(2, 4'hF, d);

      // R7 external pins: pin 0 enabled, pin 1 disabled
      bus_wrt(3, 4'h1, 32'h1);
      @(negedge clk) ext_smi_pin = 8'h03;
      repeat (2) @(posedge clk);
      @(negedge clk) check("R7 not before third edge", 32'(smi_o), 32'h0);
      @(negedge clk) check("R7 set on third edge", 32'(smi_o), 32'h1);
      bus_rd(3, 4'b1011, d); check("R8 lane2 off read", d, 32'h00010101);
      check("R8 no clear", 32'(smi_o), 32'h1);
      bus_rd(0, 4'hF, d); check("R9 summary ext", d, 32'h400);

      // R8 / R10 clearing read of the external word
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd3; bus_be = 4'hF;
      #1 check("R8 clearing read value", bus_rdata, 32'h00010101);
      check("R10 smi during read", 32'(smi_o), 32'h1);
      @(negedge clk) bus_sel = 1'b0;
      check("R10 smi next cycle", 32'(smi_o), 32'h0);
      bus_rd(3, 4'hF, d); check("R8 cleared", d, 32'h1);

      // R7 held level does not retrigger
      repeat (10) @(negedge clk);
      bus_rd(3, 4'hF, d); check("R7 level held", d, 32'h1);

      // R6 upper write bits ignored, enables rewritten
      bus_wrt(3, 4'hF, 32'hFFFFFF02);
      bus_rd(3, 4'hF, d); check("R6 write mask", d, 32'h2);
      @(negedge clk) ext_smi_pin = 8'h00;
      repeat (4) @(negedge clk);
      ext_smi_pin = 8'h02;
      repeat (5) @(negedge clk);
      bus_rd(3, 4'hF, d); check("R6/R7 pin1 status", d, 32'h00020202);
      bus_rd(3, 4'hF, d); check("R8 pin1 cleared", d, 32'h2);
      check("R10 idle", 32'(smi_o), 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule